// File: doc/BRIEF.md
# Spike Event Address Sender

This block gathers single-cycle spike pulses from an array of sender nodes and turns each pulse into an address word on a narrow shared bus. The bus is one address field of log2(NODES) bits plus a single request wire. A receiver answers each word with an acknowledge line. The node's address is the whole payload, so the only information carried is which node fired and when its word appeared.

Each node sits in one of three states. It is free to fire, or waiting with a pulse that has not gone out yet, or refractory after its word went out. A binary tree of two-way selectors picks one waiting node. That means the number of selection levels grows with log2(NODES) and not with NODES. Every tree level keeps a priority bit that flips each time it serves a side, so two siblings that keep asking are served in turn.

A sequencer drives a four-phase exchange for each word. After the word is accepted, the node is held off for a run-time number of cycles before it may fire again. When many nodes fire together, their words queue and go out one per exchange. Overload adds delay but never loses an event. A count of the nodes now waiting is output for monitoring.

Top module: `aer_sender`

## Requirements
- R1: During and right after synchronous reset, `aer_req_o` is 0, `wait_cnt_o` is 0 and every node is free.
- R2: A free node whose `spike_i` bit is sampled high at a clock edge is waiting after that edge. If the bus is idle, `aer_req_o` rises at the next edge with `aer_addr_o` equal to the node's index (bit j of `spike_i` maps to address j).
- R3: Four-phase exchange. `aer_req_o` stays high with `aer_addr_o` unchanged until `aer_ack_i` is sampled high, and it falls at that same edge. No new request is raised until `aer_ack_i` has been sampled low again.
- R4: At the edge where its word is acknowledged, a node becomes refractory for exactly `refr_len_i` cycles. It ignores `spike_i` for that whole span, and a pulse sampled at the edge after the span makes it wait again.
- R5: With `refr_len_i` equal to 0, the node is free right after the acknowledging edge, and a pulse at the next edge is accepted.
- R6: Nodes that wait at the same time are each sent exactly once, one per exchange. No pending event is dropped.
- R7: Selection goes through a binary tree. After reset every tree level prefers its lower-index side, and each level flips its preference toward the other side after it serves a word. Two siblings that keep requesting are therefore served alternately, lower index first.
- R8: `wait_cnt_o` equals the number of nodes in the waiting state, and a request is raised only when that count was nonzero.
- R9: Extra pulses on a node that is already waiting are merged, so the node's address goes out only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spike_i | input | NODES | One pulse bit per sender node |
| refr_len_i | input | REFR_W | Hold-off length in cycles after a node's word is acknowledged |
| aer_addr_o | output | log2(NODES) | Address of the node being sent |
| aer_req_o | output | 1 | Request wire of the four-phase exchange |
| aer_ack_i | input | 1 | Acknowledge from the receiver |
| wait_cnt_o | output | log2(NODES+1) | Number of nodes currently waiting |

## Verification
The bench fires pulses at nodes during their hold-off, up to the last refractory cycle and then one cycle after it. An off-by-one counter would either lose the legal pulse or take the illegal one. It holds the acknowledge high after the request drops, to catch a sequencer that re-requests too early. It also checks that the address stays steady while the request waits. Burst masks with all nodes, alternate nodes and edge nodes firing together must each yield every address exactly once: a faulty tree would repeat a node or lose one. Two sibling nodes held active must alternate, and a broken priority flip shows up as the same address twice in a row.

// File: rtl/aer_pkg.sv
package aer_pkg;

    typedef enum logic [1:0] {
        ND_FREE = 2'd0,
        ND_WAIT = 2'd1,
        ND_REFR = 2'd2
    } node_state_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_DROP = 2'd2
    } tx_state_e;

    // single-cycle events emitted by the handshake sequencer
    typedef struct packed {
        logic accept;   // grant taken from the tree this cycle
        logic sent;     // acknowledge seen for the word on the bus
    } tx_ev_t;

endpackage

// File: rtl/aer_node_cell.sv
module aer_node_cell
    import aer_pkg::*;
#(
    parameter int REFR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spike_i,
    input  logic              sent_i,
    input  logic [REFR_W-1:0] refr_len_i,
    output logic              waiting_o
);

    node_state_e       state_q;
    logic [REFR_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ND_FREE;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ND_FREE: begin
                    if (spike_i) state_q <= ND_WAIT;
                end
                ND_WAIT: begin
                    if (sent_i) begin
                        if (refr_len_i == '0) begin
                            state_q <= ND_FREE;
                        end else begin
                            state_q <= ND_REFR;
                            hold_q  <= refr_len_i;
                        end
                    end
                end
                ND_REFR: begin
                    if (hold_q <= REFR_W'(1)) state_q <= ND_FREE;
                    else                      hold_q  <= hold_q - REFR_W'(1);
                end
                default: state_q <= ND_FREE;
            endcase
        end
    end

    assign waiting_o = (state_q == ND_WAIT);

    // R4
    refr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ND_REFR) |=> (state_q != ND_WAIT));

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ND_WAIT && !sent_i) |=> (state_q == ND_WAIT));

endmodule

// File: rtl/aer_tree_arb.sv
module aer_tree_arb #(
    parameter int NODES  = 8,
    parameter int ADDR_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODES-1:0]  req_i,
    input  logic              accept_i,
    output logic              any_o,
    output logic [ADDR_W-1:0] gnt_addr_o
);

    // heap layout: internal nodes 1..NODES-1, leaves NODES..2*NODES-1
    logic [2*NODES-1:0] any_t;
    logic [NODES-1:0]   pri_q;     // 1 = prefer right child next
    logic [NODES-1:0]   visit;
    logic [NODES-1:0]   went_left;
    logic [ADDR_W-1:0]  idx;

    assign any_t[0] = 1'b0;

    for (genvar j = 0; j < NODES; j++) begin : g_leaf
        assign any_t[NODES + j] = req_i[j];
    end

    for (genvar i = 1; i < NODES; i++) begin : g_or
        assign any_t[i] = any_t[2*i] | any_t[2*i + 1];
    end

    assign any_o = any_t[1];

    always_comb begin
        idx       = ADDR_W'(1);
        visit     = '0;
        went_left = '0;
        for (int lvl = 0; lvl < ADDR_W; lvl++) begin
            visit[idx] = 1'b1;
            if (any_t[{idx, 1'b0}] && (!any_t[{idx, 1'b1}] || !pri_q[idx])) begin
                went_left[idx] = 1'b1;
                idx = ADDR_W'({idx, 1'b0});
            end else begin
                idx = ADDR_W'({idx, 1'b1});
            end
        end
        gnt_addr_o = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q <= '0;
        end else if (accept_i) begin
            for (int i = 1; i < NODES; i++) begin
                if (visit[i]) pri_q[i] <= went_left[i];
            end
        end
    end

    // R7
    gnt_valid_chk: assert property (@(posedge clk) disable iff (rst)
        any_o |-> req_i[gnt_addr_o]);

    // R7
    pri_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(pri_q));

endmodule

// File: rtl/aer_tx_fsm.sv
module aer_tx_fsm
    import aer_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_i,
    input  logic [ADDR_W-1:0] gnt_addr_i,
    input  logic              ack_i,
    output tx_ev_t            ev_o,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);

    tx_state_e         st_q;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        ev_o.accept = (st_q == TX_IDLE) && any_i;
        ev_o.sent   = (st_q == TX_REQ) && ack_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TX_IDLE;
            req_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (any_i) begin
                        addr_q <= gnt_addr_i;
                        req_q  <= 1'b1;
                        st_q   <= TX_REQ;
                    end
                end
                TX_REQ: begin
                    if (ack_i) begin
                        req_q <= 1'b0;
                        st_q  <= TX_DROP;
                    end
                end
                TX_DROP: begin
                    if (!ack_i) st_q <= TX_IDLE;
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign req_o  = req_q;
    assign addr_o = addr_q;

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && $past(req_q)) |-> $stable(addr_q));

    // R3
    req_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q) |-> $past(ack_i));

    // R3
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> !$past(ack_i));

endmodule

// File: rtl/aer_sender.sv
module aer_sender
    import aer_pkg::*;
#(
    parameter  int NODES  = 8,
    parameter  int REFR_W = 8,
    localparam int ADDR_W = $clog2(NODES),
    localparam int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODES-1:0]  spike_i,
    input  logic [REFR_W-1:0] refr_len_i,
    output logic [ADDR_W-1:0] aer_addr_o,
    output logic              aer_req_o,
    input  logic              aer_ack_i,
    output logic [CNT_W-1:0]  wait_cnt_o
);

    logic [NODES-1:0]  wait_vec;
    logic              any_wait;
    logic [ADDR_W-1:0] gnt_addr;
    tx_ev_t            tx_ev;

    for (genvar j = 0; j < NODES; j++) begin : g_node
        logic sent_here;
        assign sent_here = tx_ev.sent && (aer_addr_o == ADDR_W'(j));
        aer_node_cell #(.REFR_W(REFR_W)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .spike_i    (spike_i[j]),
            .sent_i     (sent_here),
            .refr_len_i (refr_len_i),
            .waiting_o  (wait_vec[j])
        );
    end

    aer_tree_arb #(.NODES(NODES), .ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req_i      (wait_vec),
        .accept_i   (tx_ev.accept),
        .any_o      (any_wait),
        .gnt_addr_o (gnt_addr)
    );

    aer_tx_fsm #(.ADDR_W(ADDR_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .any_i      (any_wait),
        .gnt_addr_i (gnt_addr),
        .ack_i      (aer_ack_i),
        .ev_o       (tx_ev),
        .req_o      (aer_req_o),
        .addr_o     (aer_addr_o)
    );

    always_comb begin
        wait_cnt_o = '0;
        for (int i = 0; i < NODES; i++) begin
            wait_cnt_o = wait_cnt_o + CNT_W'(wait_vec[i]);
        end
    end

    // R8
    grant_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(aer_req_o) |-> ($past(wait_cnt_o) != '0));

    // R6
    sent_is_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ev.sent |-> wait_vec[aer_addr_o]);

endmodule

// File: tb/aer_sender_tb.sv
module aer_sender_tb;

    localparam int NODES  = 8;
    localparam int REFR_W = 8;
    localparam int NVEC   = 6;

    localparam logic [7:0] VEC_MASK [NVEC] = '{8'h01, 8'h80, 8'hFF, 8'h5A, 8'h24, 8'hC3};
    localparam int         VEC_CNT  [NVEC] = '{1, 1, 8, 4, 2, 4};

    logic              clk = 1'b0;
    logic              rst;
    logic [NODES-1:0]  spike;
    logic [REFR_W-1:0] refr;
    logic [2:0]        addr;
    logic              req;
    logic              ack;
    logic [3:0]        cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    aer_sender #(.NODES(NODES), .REFR_W(REFR_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .spike_i    (spike),
        .refr_len_i (refr),
        .aer_addr_o (addr),
        .aer_req_o  (req),
        .aer_ack_i  (ack),
        .wait_cnt_o (cnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        spike = '0;
        ack   = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // waits for a request, checks the exchange, ends just after the ack edge (ack left high)
    task automatic serve(output logic [2:0] a);
        int waited = 0;
        ack = 1'b0;
        while (!req && waited < 60) begin
            tick();
            waited++;
        end
        chk(req, "R6 request expected", int'(req), 1);
        a = addr;
        tick();
        chk(req && addr == a, "R3 address held while waiting for ack", int'(addr), int'(a));
        ack = 1'b1;
        tick();
        chk(!req, "R3 request drops on ack", int'(req), 0);
    endtask

    initial begin
        logic [2:0] a;
        logic [7:0] seen;
        refr = '0;
        do_reset();
        chk(req == 1'b0, "R1 req after reset", int'(req), 0);
        chk(cnt == 4'd0, "R1 count after reset", int'(cnt), 0);

        // R2 / R3 / R8 latency and exchange
        spike = 8'h08;
        tick();
        spike = '0;
        chk(cnt == 4'd1, "R8 one node waiting", int'(cnt), 1);
        chk(req == 1'b0, "R2 no request yet", int'(req), 0);
        tick();
        chk(req == 1'b1, "R2 request raised", int'(req), 1);
        chk(addr == 3'd3, "R2 address of node 3", int'(addr), 3);
        spike = 8'h20;
        tick();
        spike = '0;
        chk(cnt == 4'd2, "R8 two nodes waiting", int'(cnt), 2);
        for (int k = 0; k < 2; k++) begin
            tick();
            chk(req && addr == 3'd3, "R3 hold without ack", int'(addr), 3);
        end
        ack = 1'b1;
        tick();
        chk(req == 1'b0, "R3 req falls at ack edge", int'(req), 1'b0);
        chk(cnt == 4'd1, "R8 count after send", int'(cnt), 1);
        for (int k = 0; k < 2; k++) begin
            tick();
            chk(req == 1'b0, "R3 no new request while ack high", int'(req), 0);
        end
        ack = 1'b0;
        tick();
        chk(req == 1'b0, "R3 idle step after ack low", int'(req), 0);
        tick();
        chk(req && addr == 3'd5, "R3 next word after ack low", int'(addr), 5);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        tick();

        // R4 refractory span of 4 cycles
        do_reset();
        refr = 8'd4;
        spike = 8'h04;
        tick();
        spike = '0;
        serve(a);
        chk(a == 3'd2, "R4 node 2 sent", int'(a), 2);
        ack = 1'b0;
        spike = 8'h04;
        for (int k = 0; k < 4; k++) tick();
        spike = '0;
        chk(cnt == 4'd0, "R4 pulses ignored while refractory", int'(cnt), 0);
        chk(req == 1'b0, "R4 no request from refractory node", int'(req), 0);
        spike = 8'h04;
        tick();
        spike = '0;
        chk(cnt == 4'd1, "R4 pulse accepted after span", int'(cnt), 1);
        serve(a);
        ack = 1'b0;
        tick();

        // R5 zero hold-off
        do_reset();
        refr = 8'd0;
        spike = 8'h40;
        tick();
        spike = '0;
        serve(a);
        chk(a == 3'd6, "R5 node 6 sent", int'(a), 6);
        ack = 1'b0;
        spike = 8'h40;
        tick();
        spike = '0;
        chk(cnt == 4'd1, "R5 free right after ack", int'(cnt), 1);
        serve(a);
        ack = 1'b0;
        tick();

        // R7 sibling alternation
        do_reset();
        refr = 8'd0;
        spike = 8'h03;
        for (int k = 0; k < 4; k++) begin
            serve(a);
            ack = 1'b0;
            chk(a == 3'(k % 2), "R7 siblings alternate", int'(a), k % 2);
        end
        spike = '0;
        tick();
        while (req) begin
            serve(a);
            ack = 1'b0;
            tick();
        end

        // R7 reset preference across the root
        do_reset();
        spike = 8'h81;
        tick();
        spike = '0;
        serve(a);
        ack = 1'b0;
        chk(a == 3'd0, "R7 lower side first after reset", int'(a), 0);
        serve(a);
        ack = 1'b0;
        chk(a == 3'd7, "R7 other side next", int'(a), 7);
        tick();

        // R9 merged pulses
        do_reset();
        spike = 8'h10;
        tick();
        tick();
        spike = '0;
        serve(a);
        ack = 1'b0;
        chk(a == 3'd4, "R9 node 4 sent", int'(a), 4);
        for (int k = 0; k < 6; k++) begin
            tick();
            chk(req == 1'b0, "R9 no second word", int'(req), 0);
        end
        chk(cnt == 4'd0, "R9 nothing left waiting", int'(cnt), 0);

        // R6 / R8 burst table
        do_reset();
        refr = 8'd20;
        for (int v = 0; v < NVEC; v++) begin
            spike = VEC_MASK[v];
            tick();
            spike = '0;
            chk(int'(cnt) == VEC_CNT[v], "R8 burst count", int'(cnt), VEC_CNT[v]);
            seen = '0;
            for (int p = 0; p < VEC_CNT[v]; p++) begin
                serve(a);
                ack = 1'b0;
                chk(VEC_MASK[v][a] && !seen[a], "R6 address from burst, once", int'(a), -1);
                seen[a] = 1'b1;
            end
            chk(seen == VEC_MASK[v], "R6 every burst node sent", int'(seen), int'(VEC_MASK[v]));
            repeat (25) tick();
            chk(req == 1'b0 && cnt == 4'd0, "R6 bus quiet after burst", int'(cnt), 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule